// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the slave side of the serial port of a small flash memory. It runs on the chip's system clock. It samples chip select, serial clock, serial input and the pause pin, and finds the serial clock edges itself. Input bits are taken on rising serial clock edges and output bits change on falling edges. The host may idle the serial clock either low or high. The first byte after select is the command. The block then collects an address and any dummy bytes as the command requires, and streams out array data, the status byte or the identification bytes.

Array data comes from a byte-wide read port that the block drives. Writes and erases are not carried out here. The block reports them as strobes with a command code, an address and a data byte, and separate logic acts on them. That logic holds the enable latch, the protection rules and the program timers, and it drives the busy flag and the status byte that this block reads. While the block is paused by the hold pin, the output is released and the transfer keeps its place.

Top module: `spi_flash_frontend`

## Requirements
- R1: After reset, and from the second cycle that chip select is high, so_oe_o is 0, and no cmd_valid_o, wr_byte_valid_o or rd_req_o pulse occurs while select stays high.
- R2: Command 05h streams status_i out MSB first, one bit per falling edge. The byte is sampled again at the start of each output byte and repeats for as long as select stays low.
- R3: Command 03h followed by three address bytes, MSB first, streams array data from rd_data_i starting at the address. Only the low ADDR_W address bits are used. The address steps up by one per byte and wraps from 2^ADDR_W-1 to 0.
- R4: Command 0Bh takes three address bytes and one dummy byte, then streams array data exactly as in R3.
- R5: Command ABh takes three dummy bytes and then outputs 9Dh, then DEV_ID (default 7Ch), then 7Fh. 7Fh repeats after that.
- R6: Commands 06h, 04h and C7h give one cmd_valid_o pulse when select rises after exactly 8 bits, with cmd_kind_o set to 1, 2 and 7 respectively. If any further rising serial clock edge comes before select rises, the command is dropped.
- R7: Command 01h followed by one data byte gives, when select rises after exactly 16 bits, a cmd_valid_o pulse with cmd_kind_o = 3 and cmd_data_o equal to that byte.
- R8: Command 02h followed by three address bytes and N data bytes gives one wr_byte_valid_o pulse per byte. wr_addr_o starts at the address, and its low PAGE_W bits step up and wrap inside the page. When select rises on a byte boundary with N >= 1, one cmd_valid_o pulse follows with cmd_kind_o = 4 and cmd_addr_o equal to the start address. If select rises off a byte boundary, there is no such pulse.
- R9: Commands D7h and D8h followed by three address bytes give, when select rises after exactly 32 bits, a cmd_valid_o pulse with cmd_kind_o = 5 (D7h) or 6 (D8h) and cmd_addr_o equal to the address.
- R10: An opcode outside the set above leaves so_oe_o at 0 and produces no strobe until the next select falling edge, whatever follows on si_i.
- R11: If busy_i is 1 when the command byte completes, every command except 05h is dropped, with no output and no strobe. 05h still works.
- R12: If hold_n_i goes low while sck_i is low, the transfer pauses. so_oe_o is 0 and serial clock edges are ignored until hold_n_i returns high with sck_i low. The transfer then resumes from the same bit.
- R13: A transfer that starts with sck_i high at the select falling edge behaves the same as one that starts with sck_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, sampled on clk |
| si_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Pause request, active low |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o (0 = high impedance) |
| busy_i | input | 1 | Internal write cycle in progress |
| status_i | input | 8 | Status byte to stream for 05h |
| rd_req_o | output | 1 | One-cycle array read request |
| rd_addr_o | output | ADDR_W | Array read address, valid with rd_req_o |
| rd_data_i | input | 8 | Array byte, valid from the cycle after rd_req_o until the next request |
| wr_byte_valid_o | output | 1 | One program data byte received |
| wr_byte_o | output | 8 | Program data byte |
| wr_addr_o | output | ADDR_W | Target address of the program byte |
| cmd_valid_o | output | 1 | One-cycle command strobe after select rises |
| cmd_kind_o | output | 3 | 1 set-enable, 2 clear-enable, 3 status write, 4 program, 5 sector erase, 6 block erase, 7 chip erase |
| cmd_addr_o | output | ADDR_W | Address of program or erase |
| cmd_data_o | output | 8 | Data byte of status write |

## Verification
A bit counter that drifts from the true byte framing shows up on the first byte after the command. The streamed bits come out shifted, or an address is formed from the wrong bits, and that is visible at rd_addr_o within one serial byte. If the phase register does not mute after an unknown or rejected opcode, so_oe_o rises on the next falling edge or a strobe fires when select rises. A wrong hold flag either lets the output stay driven during the pause or loses a bit. Both show up in the byte read back after the resume.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

    localparam logic [7:0] OP_WEN_SET  = 8'h06;
    localparam logic [7:0] OP_WEN_CLR  = 8'h04;
    localparam logic [7:0] OP_STAT_RD  = 8'h05;
    localparam logic [7:0] OP_STAT_WR  = 8'h01;
    localparam logic [7:0] OP_RD       = 8'h03;
    localparam logic [7:0] OP_RD_FAST  = 8'h0B;
    localparam logic [7:0] OP_PROG     = 8'h02;
    localparam logic [7:0] OP_SECT_ER  = 8'hD7;
    localparam logic [7:0] OP_BLK_ER   = 8'hD8;
    localparam logic [7:0] OP_CHIP_ER  = 8'hC7;
    localparam logic [7:0] OP_IDENT    = 8'hAB;

    localparam logic [7:0] IDENT_FIRST = 8'h9D;
    localparam logic [7:0] IDENT_LAST  = 8'h7F;

    typedef enum logic [2:0] {
        PH_OPCODE, PH_ADDR, PH_DUMMY, PH_DATA_IN, PH_STREAM, PH_ARMED, PH_MUTE
    } phase_e;

    typedef enum logic [1:0] {SRC_ARRAY, SRC_STATUS, SRC_IDENT} src_e;

    typedef enum logic [2:0] {
        K_NONE = 3'd0, K_WEN_SET = 3'd1, K_WEN_CLR = 3'd2, K_STAT_WR = 3'd3,
        K_PROGRAM = 3'd4, K_SECT_ER = 3'd5, K_BLK_ER = 3'd6, K_CHIP_ER = 3'd7
    } kind_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic sel_start;
        logic sel_end;
    } pin_ev_t;

    function automatic kind_e kind_of(input logic [7:0] op);
        case (op)
            OP_WEN_SET: return K_WEN_SET;
            OP_WEN_CLR: return K_WEN_CLR;
            OP_STAT_WR: return K_STAT_WR;
            OP_SECT_ER: return K_SECT_ER;
            OP_BLK_ER:  return K_BLK_ER;
            OP_CHIP_ER: return K_CHIP_ER;
            default:    return K_NONE;
        endcase
    endfunction

    function automatic logic [7:0] pick_out(input src_e src, input logic [1:0] idx,
                                            input logic [7:0] dev, input logic [7:0] stat,
                                            input logic [7:0] rdata);
        case (src)
            SRC_STATUS: return stat;
            SRC_IDENT:  return (idx == 2'd0) ? IDENT_FIRST : ((idx == 2'd1) ? dev : IDENT_LAST);
            default:    return rdata;
        endcase
    endfunction

endpackage

// File: rtl/fe_pin_front.sv
module fe_pin_front
    import flash_fe_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n_i,
    input  logic    sck_i,
    input  logic    hold_n_i,
    output pin_ev_t ev_o,
    output logic    held_o
);

    logic sck_q, cs_q, held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q  <= 1'b0;
            cs_q   <= 1'b1;
            held_q <= 1'b0;
        end else begin
            sck_q <= sck_i;
            cs_q  <= cs_n_i;
            // pause state only changes while the serial clock is low
            if (cs_n_i)
                held_q <= 1'b0;
            else if (!sck_i)
                held_q <= !hold_n_i;
        end
    end

    logic live;
    assign live           = !cs_n_i && !cs_q && !held_q;
    assign ev_o.rise      = live &&  sck_i && !sck_q;
    assign ev_o.fall      = live && !sck_i &&  sck_q;
    assign ev_o.sel_start = !cs_n_i &&  cs_q;
    assign ev_o.sel_end   =  cs_n_i && !cs_q;
    assign held_o         = held_q;

    p_hold_clear_at_select_r12: assert property (@(posedge clk) disable iff (rst)
        ev_o.sel_start |-> !held_q);

endmodule

// File: rtl/fe_tx_shift.sv
module fe_tx_shift
    import flash_fe_pkg::*;
#(
    parameter logic [7:0] DEV_ID = 8'h7C
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic       shift_i,
    input  logic       clear_i,
    input  src_e       src_i,
    input  logic [1:0] idx_i,
    input  logic [7:0] status_i,
    input  logic [7:0] rdata_i,
    input  logic       held_i,
    output logic       so_o,
    output logic       so_oe_o
);

    logic [7:0] sr;
    logic       driving;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            sr      <= '0;
            driving <= 1'b0;
        end else if (load_i) begin
            sr      <= pick_out(src_i, idx_i, DEV_ID, status_i, rdata_i);
            driving <= 1'b1;
        end else if (shift_i) begin
            sr <= {sr[6:0], 1'b0};
        end
    end

    assign so_o    = sr[7];
    assign so_oe_o = driving && !held_i;

    p_load_excludes_shift_r2: assert property (@(posedge clk) disable iff (rst)
        load_i |-> !shift_i);

endmodule

// File: rtl/fe_cmd_ctrl.sv
module fe_cmd_ctrl
    import flash_fe_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  pin_ev_t           ev_i,
    input  logic              si_i,
    input  logic              busy_i,
    output logic              tx_load_o,
    output logic              tx_shift_o,
    output logic              tx_clear_o,
    output src_e              src_o,
    output logic [1:0]        idx_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_byte_valid_o,
    output logic [7:0]        wr_byte_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              cmd_valid_o,
    output logic [2:0]        cmd_kind_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [7:0]        cmd_data_o
);

    phase_e            phase;
    src_e              src_q;
    kind_e             kind_q;
    logic [2:0]        bit_cnt;
    logic [1:0]        byte_cnt, out_idx;
    logic [7:0]        opcode, stat_q, wr_byte_q;
    logic [6:0]        in_sr;
    logic [ADDR_W-1:0] addr_q, wr_ptr, wr_addr_q;
    logic              got_byte, rd_req_q, wr_v_q, cmd_v_q;

    logic [7:0]        byte_full;
    logic [ADDR_W-1:0] addr_nx;
    assign byte_full = {in_sr, si_i};
    assign addr_nx   = {addr_q[ADDR_W-9:0], byte_full};

    always_ff @(posedge clk) begin
        rd_req_q <= 1'b0;
        wr_v_q   <= 1'b0;
        cmd_v_q  <= 1'b0;
        if (rst) begin
            phase    <= PH_OPCODE;
            src_q    <= SRC_ARRAY;
            kind_q   <= K_NONE;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            out_idx  <= '0;
            opcode   <= '0;
            stat_q   <= '0;
            wr_byte_q <= '0;
            in_sr    <= '0;
            addr_q   <= '0;
            wr_ptr   <= '0;
            wr_addr_q <= '0;
            got_byte <= 1'b0;
        end else if (ev_i.sel_start || ev_i.sel_end) begin
            if (ev_i.sel_end && phase == PH_ARMED) begin
                cmd_v_q <= 1'b1;
                kind_q  <= kind_of(opcode);
            end else if (ev_i.sel_end && phase == PH_DATA_IN && opcode == OP_PROG
                         && bit_cnt == 3'd0 && got_byte) begin
                cmd_v_q <= 1'b1;
                kind_q  <= K_PROGRAM;
            end
            phase    <= PH_OPCODE;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            out_idx  <= '0;
            got_byte <= 1'b0;
        end else if (ev_i.rise) begin
            in_sr   <= byte_full[6:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (phase == PH_ARMED) begin
                phase <= PH_MUTE;   // trailing clocks cancel the command
            end else if (bit_cnt == 3'd7) begin
                case (phase)
                    PH_OPCODE: begin
                        opcode   <= byte_full;
                        byte_cnt <= '0;
                        if (busy_i && byte_full != OP_STAT_RD)
                            phase <= PH_MUTE;
                        else case (byte_full)
                            OP_WEN_SET, OP_WEN_CLR, OP_CHIP_ER: phase <= PH_ARMED;
                            OP_STAT_RD: begin phase <= PH_STREAM; src_q <= SRC_STATUS; end
                            OP_STAT_WR: phase <= PH_DATA_IN;
                            OP_RD, OP_RD_FAST, OP_PROG, OP_SECT_ER, OP_BLK_ER: phase <= PH_ADDR;
                            OP_IDENT:   phase <= PH_DUMMY;
                            default:    phase <= PH_MUTE;
                        endcase
                    end
                    PH_ADDR: begin
                        addr_q   <= addr_nx;
                        byte_cnt <= byte_cnt + 2'd1;
                        if (byte_cnt == 2'd2) begin
                            byte_cnt <= '0;
                            case (opcode)
                                OP_RD: begin
                                    phase    <= PH_STREAM;
                                    src_q    <= SRC_ARRAY;
                                    rd_req_q <= 1'b1;
                                end
                                OP_RD_FAST: phase <= PH_DUMMY;
                                OP_PROG: begin
                                    phase  <= PH_DATA_IN;
                                    wr_ptr <= addr_nx;
                                end
                                default: phase <= PH_ARMED;
                            endcase
                        end
                    end
                    PH_DUMMY: begin
                        byte_cnt <= byte_cnt + 2'd1;
                        if (opcode == OP_RD_FAST) begin
                            phase    <= PH_STREAM;
                            src_q    <= SRC_ARRAY;
                            rd_req_q <= 1'b1;
                        end else if (byte_cnt == 2'd2) begin
                            phase <= PH_STREAM;
                            src_q <= SRC_IDENT;
                        end
                    end
                    PH_DATA_IN: begin
                        if (opcode == OP_STAT_WR) begin
                            stat_q <= byte_full;
                            phase  <= PH_ARMED;
                        end else begin
                            wr_v_q    <= 1'b1;
                            wr_byte_q <= byte_full;
                            wr_addr_q <= wr_ptr;
                            wr_ptr[PAGE_W-1:0] <= wr_ptr[PAGE_W-1:0] + 1'b1;
                            got_byte  <= 1'b1;
                        end
                    end
                    PH_STREAM: begin
                        if (src_q == SRC_ARRAY) begin
                            addr_q   <= addr_q + 1'b1;
                            rd_req_q <= 1'b1;
                        end else if (src_q == SRC_IDENT && out_idx != 2'd2) begin
                            out_idx <= out_idx + 2'd1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign tx_load_o       = ev_i.fall && phase == PH_STREAM && bit_cnt == 3'd0;
    assign tx_shift_o      = ev_i.fall && phase == PH_STREAM && bit_cnt != 3'd0;
    assign tx_clear_o      = ev_i.sel_start || ev_i.sel_end;
    assign src_o           = src_q;
    assign idx_o           = out_idx;
    assign rd_req_o        = rd_req_q;
    assign rd_addr_o       = addr_q;
    assign wr_byte_valid_o = wr_v_q;
    assign wr_byte_o       = wr_byte_q;
    assign wr_addr_o       = wr_addr_q;
    assign cmd_valid_o     = cmd_v_q;
    assign cmd_kind_o      = kind_q;
    assign cmd_addr_o      = addr_q;
    assign cmd_data_o      = stat_q;

    p_single_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_v_q, wr_v_q, rd_req_q}));
    p_kind_named_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_v_q |-> kind_q != K_NONE);
    p_byte_spacing_r8: assert property (@(posedge clk) disable iff (rst)
        wr_v_q |=> !wr_v_q);
    p_page_kept_r8: assert property (@(posedge clk) disable iff (rst)
        wr_v_q |-> wr_addr_q[ADDR_W-1:PAGE_W] == addr_q[ADDR_W-1:PAGE_W]);

endmodule

// File: rtl/spi_flash_frontend.sv
module spi_flash_frontend
    import flash_fe_pkg::*;
#(
    parameter int         ADDR_W = 17,
    parameter int         PAGE_W = 8,
    parameter logic [7:0] DEV_ID = 8'h7C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_i,
    input  logic              sck_i,
    input  logic              si_i,
    input  logic              hold_n_i,
    output logic              so_o,
    output logic              so_oe_o,
    input  logic              busy_i,
    input  logic [7:0]        status_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic              wr_byte_valid_o,
    output logic [7:0]        wr_byte_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              cmd_valid_o,
    output logic [2:0]        cmd_kind_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [7:0]        cmd_data_o
);

    pin_ev_t    ev;
    logic       held, tx_load, tx_shift, tx_clear;
    src_e       src;
    logic [1:0] idx;

    fe_pin_front u_pins (
        .clk      (clk),
        .rst      (rst),
        .cs_n_i   (cs_n_i),
        .sck_i    (sck_i),
        .hold_n_i (hold_n_i),
        .ev_o     (ev),
        .held_o   (held)
    );

    fe_cmd_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .ev_i            (ev),
        .si_i            (si_i),
        .busy_i          (busy_i),
        .tx_load_o       (tx_load),
        .tx_shift_o      (tx_shift),
        .tx_clear_o      (tx_clear),
        .src_o           (src),
        .idx_o           (idx),
        .rd_req_o        (rd_req_o),
        .rd_addr_o       (rd_addr_o),
        .wr_byte_valid_o (wr_byte_valid_o),
        .wr_byte_o       (wr_byte_o),
        .wr_addr_o       (wr_addr_o),
        .cmd_valid_o     (cmd_valid_o),
        .cmd_kind_o      (cmd_kind_o),
        .cmd_addr_o      (cmd_addr_o),
        .cmd_data_o      (cmd_data_o)
    );

    fe_tx_shift #(.DEV_ID(DEV_ID)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .load_i   (tx_load),
        .shift_i  (tx_shift),
        .clear_i  (tx_clear),
        .src_i    (src),
        .idx_i    (idx),
        .status_i (status_i),
        .rdata_i  (rd_data_i),
        .held_i   (held),
        .so_o     (so_o),
        .so_oe_o  (so_oe_o)
    );

    p_quiet_deselected_r1: assert property (@(posedge clk) disable iff (rst)
        (cs_n_i && $past(cs_n_i)) |-> !so_oe_o);

endmodule

// File: tb/spi_flash_frontend_tb.sv
module spi_flash_frontend_tb_top;

    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
    logic [7:0]    status = 8'h00, rd_data = 8'h00;
    logic          so, so_oe, rd_req, wr_v, cmd_v;
    logic [AW-1:0] rd_addr, wr_addr, cmd_addr;
    logic [7:0]    wr_byte, cmd_data;
    logic [2:0]    cmd_kind;

    always #2 clk = ~clk;

    spi_flash_frontend #(.ADDR_W(AW), .PAGE_W(8), .DEV_ID(8'h7C)) dut_i (
        .clk(clk), .rst(rst), .cs_n_i(cs_n), .sck_i(sck), .si_i(si), .hold_n_i(hold_n),
        .so_o(so), .so_oe_o(so_oe), .busy_i(busy), .status_i(status),
        .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .wr_byte_valid_o(wr_v), .wr_byte_o(wr_byte), .wr_addr_o(wr_addr),
        .cmd_valid_o(cmd_v), .cmd_kind_o(cmd_kind), .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data)
    );

    function automatic logic [7:0] mem_f(input logic [AW-1:0] a);
        return (a[7:0] ^ a[15:8]) + {7'd0, a[16]} + 8'h3C;
    endfunction

    always_ff @(posedge clk) if (rd_req) rd_data <= mem_f(rd_addr);

    int            checks = 0, errors = 0, cmd_cnt = 0, wr_cnt = 0, strobe_idle = 0;
    logic [2:0]    last_kind;
    logic [AW-1:0] last_addr;
    logic [7:0]    last_data;
    logic [AW-1:0] wr_a [8];
    logic [7:0]    wr_d [8];
    logic          done = 1'b0;

    always @(posedge clk) begin
        if (cmd_v) begin cmd_cnt <= cmd_cnt + 1; last_kind <= cmd_kind; last_addr <= cmd_addr; last_data <= cmd_data; end
        if (wr_v && wr_cnt < 8) begin wr_a[wr_cnt] <= wr_addr; wr_d[wr_cnt] <= wr_byte; wr_cnt <= wr_cnt + 1; end
        if (!rst && cs_n && (cmd_v === 1'b0) && (wr_v || rd_req)) strobe_idle <= strobe_idle + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_mon();
        waitn(2);
        cmd_cnt = 0; wr_cnt = 0;
    endtask

    task automatic sel(input logic mode3);
        sck = mode3; waitn(4);
        cs_n = 1'b0; waitn(4);
    endtask

    task automatic desel(input logic mode3);
        if (!mode3) begin sck = 1'b0; waitn(4); end
        cs_n = 1'b1; waitn(6);
    endtask

    task automatic bit_io(input logic b, output logic o, output logic oe);
        sck = 1'b0; si = b; waitn(4);
        o = so; oe = so_oe;
        sck = 1'b1; waitn(4);
    endtask

    task automatic byte_io(input logic [7:0] b, output logic [7:0] r, output logic all_oe, output logic any_oe);
        logic o, oe;
        all_oe = 1'b1; any_oe = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            bit_io(b[i], o, oe);
            r[i] = o; all_oe &= oe; any_oe |= oe;
        end
    endtask

    typedef struct packed {
        logic [7:0] op;
        logic [4:0] extra;
        logic       bsy;
        logic [1:0] n;
        logic [2:0] kind;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{8'h06, 5'd0,  1'b0, 2'd1, 3'd1},
        '{8'h04, 5'd0,  1'b0, 2'd1, 3'd2},
        '{8'hC7, 5'd0,  1'b0, 2'd1, 3'd7},
        '{8'h06, 5'd3,  1'b0, 2'd0, 3'd0},
        '{8'h06, 5'd0,  1'b1, 2'd0, 3'd0},
        '{8'hC7, 5'd0,  1'b1, 2'd0, 3'd0},
        '{8'h5A, 5'd16, 1'b0, 2'd0, 3'd0}
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] r;
        logic a_oe, n_oe, o, oe, dummy_all;
        waitn(5);
        rst = 1'b0;
        waitn(3);
        // R1 reset state
        chk("R1 oe after reset", so_oe, 0);
        chk("R1 no strobe", cmd_cnt + wr_cnt, 0);

        // R6 R10 R11 table of short commands
        for (int v = 0; v < 7; v++) begin
            string tag;
            tag = VECS[v].bsy ? "R11" : ((VECS[v].op == 8'h5A) ? "R10" : "R6");
            clear_mon();
            busy = VECS[v].bsy;
            sel(1'b0);
            byte_io(VECS[v].op, r, dummy_all, n_oe);
            for (int k = 0; k < VECS[v].extra; k++) begin
                bit_io(1'b1, o, oe); n_oe |= oe;
            end
            desel(1'b0);
            busy = 1'b0;
            chk(tag, cmd_cnt, VECS[v].n);
            if (VECS[v].n != 0) chk(tag, last_kind, VECS[v].kind);
            chk(tag, n_oe, 0);
        end

        // R2 status stream repeats
        clear_mon(); status = 8'hA5;
        sel(1'b0); byte_io(8'h05, r, a_oe, n_oe);
        byte_io(8'h00, r, a_oe, n_oe); chk("R2 status byte 1", r, 8'hA5); chk("R2 oe", a_oe, 1);
        status = 8'h3C;
        byte_io(8'h00, r, a_oe, n_oe); chk("R2 status byte 2", r, 8'h3C);
        desel(1'b0);
        chk("R1 oe after deselect", so_oe, 0);

        // R3 read with upper address bits ignored
        sel(1'b0); byte_io(8'h03, r, a_oe, n_oe);
        byte_io(8'hFE, r, a_oe, n_oe); byte_io(8'h12, r, a_oe, n_oe); byte_io(8'h34, r, a_oe, n_oe);
        for (int k = 0; k < 3; k++) begin
            byte_io(8'h00, r, a_oe, n_oe);
            chk("R3 read data", r, mem_f(AW'(17'h01234 + k)));
        end
        desel(1'b0);

        // R3 wrap at top of array
        sel(1'b0); byte_io(8'h03, r, a_oe, n_oe);
        byte_io(8'h01, r, a_oe, n_oe); byte_io(8'hFF, r, a_oe, n_oe); byte_io(8'hFF, r, a_oe, n_oe);
        byte_io(8'h00, r, a_oe, n_oe); chk("R3 top byte", r, mem_f(17'h1FFFF));
        byte_io(8'h00, r, a_oe, n_oe); chk("R3 wrap to zero", r, mem_f(17'h00000));
        desel(1'b0);

        // R4 R13 fast read in idle-high clock mode
        sel(1'b1); byte_io(8'h0B, r, a_oe, n_oe);
        byte_io(8'h00, r, a_oe, n_oe); byte_io(8'h40, r, a_oe, n_oe); byte_io(8'h10, r, a_oe, n_oe);
        byte_io(8'hFF, r, a_oe, n_oe); chk("R4 no output in dummy", n_oe, 0);
        byte_io(8'h00, r, a_oe, n_oe); chk("R4 R13 fast byte 1", r, mem_f(17'h04010));
        byte_io(8'h00, r, a_oe, n_oe); chk("R4 R13 fast byte 2", r, mem_f(17'h04011));
        desel(1'b1);

        // R5 identification sequence
        sel(1'b0); byte_io(8'hAB, r, a_oe, n_oe);
        for (int k = 0; k < 3; k++) byte_io(8'h00, r, a_oe, n_oe);
        byte_io(8'h00, r, a_oe, n_oe); chk("R5 id byte 1", r, 8'h9D);
        byte_io(8'h00, r, a_oe, n_oe); chk("R5 id byte 2", r, 8'h7C);
        byte_io(8'h00, r, a_oe, n_oe); chk("R5 id byte 3", r, 8'h7F);
        byte_io(8'h00, r, a_oe, n_oe); chk("R5 id repeat", r, 8'h7F);
        desel(1'b0);

        // R7 status write
        clear_mon();
        sel(1'b0); byte_io(8'h01, r, a_oe, n_oe); byte_io(8'h8C, r, a_oe, n_oe); desel(1'b0);
        chk("R7 strobe count", cmd_cnt, 1); chk("R7 kind", last_kind, 3); chk("R7 data", last_data, 8'h8C);

        // R8 page program with in-page wrap
        clear_mon();
        sel(1'b0); byte_io(8'h02, r, a_oe, n_oe);
        byte_io(8'h00, r, a_oe, n_oe); byte_io(8'h12, r, a_oe, n_oe); byte_io(8'hFE, r, a_oe, n_oe);
        byte_io(8'h11, r, a_oe, n_oe); byte_io(8'h22, r, a_oe, n_oe); byte_io(8'h33, r, a_oe, n_oe);
        desel(1'b0);
        chk("R8 byte count", wr_cnt, 3);
        chk("R8 addr 0", wr_a[0], 17'h012FE); chk("R8 addr 1", wr_a[1], 17'h012FF);
        chk("R8 addr wrap", wr_a[2], 17'h01200); chk("R8 data 2", wr_d[2], 8'h33);
        chk("R8 commit", cmd_cnt, 1); chk("R8 kind", last_kind, 4); chk("R8 start addr", last_addr, 17'h012FE);

        // R8 off-boundary end drops the commit
        clear_mon();
        sel(1'b0); byte_io(8'h02, r, a_oe, n_oe);
        byte_io(8'h00, r, a_oe, n_oe); byte_io(8'h20, r, a_oe, n_oe); byte_io(8'h00, r, a_oe, n_oe);
        byte_io(8'h55, r, a_oe, n_oe);
        for (int k = 0; k < 3; k++) bit_io(1'b0, o, oe);
        desel(1'b0);
        chk("R8 partial byte count", wr_cnt, 1); chk("R8 no commit", cmd_cnt, 0);

        // R9 sector and block erase
        clear_mon();
        sel(1'b0); byte_io(8'hD7, r, a_oe, n_oe);
        byte_io(8'h01, r, a_oe, n_oe); byte_io(8'h80, r, a_oe, n_oe); byte_io(8'h00, r, a_oe, n_oe);
        desel(1'b0);
        chk("R9 sector kind", last_kind, 5); chk("R9 sector addr", last_addr, 17'h18000);
        sel(1'b0); byte_io(8'hD8, r, a_oe, n_oe);
        byte_io(8'h00, r, a_oe, n_oe); byte_io(8'h80, r, a_oe, n_oe); byte_io(8'h05, r, a_oe, n_oe);
        desel(1'b0);
        chk("R9 block kind", last_kind, 6); chk("R9 block addr", last_addr, 17'h08005);
        chk("R9 strobe count", cmd_cnt, 2);

        // R11 status read accepted while busy, array read refused
        busy = 1'b1; status = 8'hFF;
        sel(1'b0); byte_io(8'h05, r, a_oe, n_oe); byte_io(8'h00, r, a_oe, n_oe); desel(1'b0);
        chk("R11 status while busy", r, 8'hFF); chk("R11 status oe", a_oe, 1);
        sel(1'b0); byte_io(8'h03, r, a_oe, n_oe);
        for (int k = 0; k < 4; k++) byte_io(8'h00, r, dummy_all, n_oe);
        desel(1'b0); busy = 1'b0;
        chk("R11 read refused while busy", n_oe, 0);

        // R12 pause in the middle of an output byte
        sel(1'b0); byte_io(8'h03, r, a_oe, n_oe);
        byte_io(8'h00, r, a_oe, n_oe); byte_io(8'h01, r, a_oe, n_oe); byte_io(8'h00, r, a_oe, n_oe);
        for (int i = 7; i >= 4; i--) begin bit_io(1'b0, o, oe); r[i] = o; end
        sck = 1'b0; waitn(4);
        hold_n = 1'b0; waitn(4);
        chk("R12 released during pause", so_oe, 0);
        sck = 1'b1; waitn(4); sck = 1'b0; waitn(4);
        sck = 1'b1; waitn(4); sck = 1'b0; waitn(4);
        hold_n = 1'b1; waitn(4);
        for (int i = 3; i >= 0; i--) begin bit_io(1'b0, o, oe); r[i] = o; end
        chk("R12 byte intact across pause", r, mem_f(17'h00100));
        byte_io(8'h00, r, a_oe, n_oe); chk("R12 next byte", r, mem_f(17'h00101));
        desel(1'b0);

        chk("R1 no strobe while deselected", strobe_idle, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule